// File: doc/BRIEF.md
# Instruction Decode Stage with Deferred Override

This block is the first decode step for a fixed 32-bit instruction encoding. Each fetched word is looked up in a major table selected by bits 31..26. For a few major codes a minor table is used instead. The block produces a small control word: an execution unit, an operation code and a single-issue bit.

The table result is registered unchanged. Any correction to it is carried as a set of flags registered beside it, and the correction is applied after the register. The flags can force an illegal or replacement word, redirect the unit, or force single issue. This keeps the correction logic out of the table lookup path.

The registered pair passes through a two-entry skid register. A downstream stall input holds the output. A flush input discards what is held. A busy output tells the fetch side that the second entry is occupied.

Top module: `dec_stage`

## Requirements
- R1: The unit codes are NONE=0, ALU=1, LSU=2, BRU=3. The operation codes are ILLEGAL=0, NOP=1, ADD=2, OR=3, LOAD=4, STORE=5, BR=6, BC=7, BCREG=8, CRLOGIC=9, ADDPC=10, MULADD=11, SPR=12, FETCH_FAIL=13, MCRF=14. The major code in bits 31..26 selects the word: 14 gives ALU/ADD, 24 gives ALU/OR, 32 gives LSU/LOAD, 36 gives LSU/STORE, 18 gives BRU/BR, 16 gives BRU/BC. Major 31 indexes a minor table by bits 10..1, where 266 gives ALU/ADD, 23 gives LSU/LOAD, and 339 or 467 give ALU/SPR. Every other code gives NONE/ILLEGAL.
- R2: Major 19 is valid only when the 10-bit index {bits 5..1, bits 10..6} has one of these forms: upper half 00010 with any lower half, upper 10000 with lower 10000, or all zero. An invalid index yields NONE/ILLEGAL with single 0. A valid index takes its word from {bit5, bit3, bit2}: 0 gives ALU/MCRF, 1 gives ALU/ADDPC, 4 gives BRU/BCREG, and any other value gives ALU/CRLOGIC.
- R3: Major 4 is valid only when the 11-bit index {bits 5..0, bits 10..6} has sub-code 48 or 49 with any extension, or sub-code 51 with extension 0. The word comes from a 64-entry table indexed by bits 5..0, where 48, 49 and 51 give ALU/MULADD. An invalid index yields NONE/ILLEGAL.
- R4: The exact word 0x60000000 yields ALU/NOP. Any other major-24 word yields ALU/OR.
- R5: When the fetch-failure input is high, an output entry is produced even without a valid input, carrying ALU/FETCH_FAIL with single 1. While the registered entry already holds a fetch-failure override, a further failure produces no valid output, so only one failure goes downstream.
- R6: A major-31 SPR access (minor 339 or 467) reads the register number as {bits 15..11, bits 20..16}. Numbers 1, 8, 9 and 815 are fast and give single 0. Any other number gives single 1. The numbers 18, 19, 48 and 720 are additionally redirected to unit LSU with the operation kept as SPR.
- R7: A full override replaces the whole output word, taking priority over a unit redirect. A unit redirect changes only the unit. A force-single flag sets the single bit in either case.
- R8: An input accepted at a clock edge appears at the outputs after that edge. While stall is high, the output entry holds. A valid input arriving while the output entry is valid and stall is high goes into the second entry and raises busy. While busy is high, inputs are not captured. When stall falls, the second entry moves to the output.
- R9: A flush clears both entries' valid bits at the next edge, so valid and busy read 0.
- R10: Asynchronous reset drives valid and busy low at once.
- R11: The override flags stay paired with their own instruction through stall and skid movement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard held entries |
| stall_i | input | 1 | Downstream cannot accept |
| valid_i | input | 1 | Instruction word present |
| insn_i | input | 32 | Instruction word |
| fetch_fail_i | input | 1 | Fetch of this word failed |
| valid_o | output | 1 | Output entry valid |
| busy_o | output | 1 | Second entry occupied; fetch must hold |
| insn_o | output | 32 | Instruction word of output entry |
| unit_o | output | 2 | Execution unit code |
| op_o | output | 4 | Operation code |
| single_o | output | 1 | Single-issue required |

## Verification
The assertions assume that the fetch side honours busy and presents nothing new while it is high. The bench does present a word while busy, but only to check that the word is dropped. The single-failure property relies on flush and stall being known every cycle after reset. The stimulus therefore drives every control input at each falling edge and never leaves one undriven. The patch properties assume that an SPR-class or NOP word on the output came from its own decode. The bench keeps fetch-failure words separate by checking them against FETCH_FAIL.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int INSN_W = 32;
  localparam int MAJ_W  = 6;
  localparam int XO_W   = 10;
  localparam int SPR_W  = 10;

  typedef enum logic [1:0] {
    U_NONE = 2'd0, U_ALU = 2'd1, U_LSU = 2'd2, U_BRU = 2'd3
  } unit_e;

  typedef enum logic [3:0] {
    OP_ILL = 4'd0, OP_NOP = 4'd1, OP_ADD = 4'd2, OP_OR = 4'd3,
    OP_LOAD = 4'd4, OP_STORE = 4'd5, OP_BR = 4'd6, OP_BC = 4'd7,
    OP_BCREG = 4'd8, OP_CRL = 4'd9, OP_ADDPC = 4'd10, OP_MULADD = 4'd11,
    OP_SPR = 4'd12, OP_FFAIL = 4'd13, OP_MCRF = 4'd14
  } op_e;

  typedef struct packed {
    unit_e unit;
    op_e   op;
    logic  single;
  } ctrl_t;

  typedef struct packed {
    logic  full;       // replace whole word
    logic  unit_only;  // replace unit field only
    logic  single;     // force single issue
    ctrl_t word;
  } ovr_t;

  typedef struct packed {
    logic [INSN_W-1:0] insn;
    ctrl_t             base;
    ovr_t              ovr;
  } slot_t;

  localparam ctrl_t CW_ILLEGAL = '{unit: U_NONE, op: OP_ILL,   single: 1'b0};
  localparam ctrl_t CW_NOP     = '{unit: U_ALU,  op: OP_NOP,   single: 1'b0};
  localparam ctrl_t CW_FFAIL   = '{unit: U_ALU,  op: OP_FFAIL, single: 1'b1};

  localparam ovr_t  OVR_NONE = '{full: 1'b0, unit_only: 1'b0, single: 1'b0, word: CW_ILLEGAL};
  localparam slot_t SLOT_RST = '{insn: '0, base: CW_ILLEGAL, ovr: OVR_NONE};

  localparam logic [XO_W-1:0] XO31_ADD   = 10'd266;
  localparam logic [XO_W-1:0] XO31_LOAD  = 10'd23;
  localparam logic [XO_W-1:0] XO31_MFSPR = 10'd339;
  localparam logic [XO_W-1:0] XO31_MTSPR = 10'd467;

  localparam logic [SPR_W-1:0] SPRN_XER   = 10'd1;
  localparam logic [SPR_W-1:0] SPRN_LINK  = 10'd8;
  localparam logic [SPR_W-1:0] SPRN_COUNT = 10'd9;
  localparam logic [SPR_W-1:0] SPRN_TGT   = 10'd815;
  localparam logic [SPR_W-1:0] SPRN_FSTAT = 10'd18;
  localparam logic [SPR_W-1:0] SPRN_FADDR = 10'd19;
  localparam logic [SPR_W-1:0] SPRN_ASID  = 10'd48;
  localparam logic [SPR_W-1:0] SPRN_PTAB  = 10'd720;

  function automatic logic spr_is_fast(input logic [SPR_W-1:0] n);
    return (n == SPRN_XER) || (n == SPRN_LINK) || (n == SPRN_COUNT) || (n == SPRN_TGT);
  endfunction

  function automatic logic spr_is_mmu(input logic [SPR_W-1:0] n);
    return (n == SPRN_FSTAT) || (n == SPRN_FADDR) || (n == SPRN_ASID) || (n == SPRN_PTAB);
  endfunction
endpackage

// File: rtl/dec_lookup.sv
module dec_lookup
  import dec_pkg::*;
#(
  parameter logic [INSN_W-1:0] NOP_PATTERN = 32'h6000_0000
) (
  input  logic [INSN_W-1:0] insn_i,
  input  logic              valid_i,
  input  logic              fetch_fail_i,
  input  logic              held_ffail_i,
  output logic              valid_o,
  output ctrl_t             base_o,
  output ovr_t              ovr_o
);
  localparam logic [MAJ_W-1:0] NOP_MAJ = NOP_PATTERN[INSN_W-1 -: MAJ_W];

  logic [MAJ_W-1:0] major;
  logic [XO_W-1:0]  xo31;
  logic [SPR_W-1:0] sprn;

  assign major = insn_i[INSN_W-1 -: MAJ_W];
  assign xo31  = insn_i[10:1];
  assign sprn  = {insn_i[15:11], insn_i[20:16]};

  function automatic ctrl_t mk(input unit_e u, input op_e o);
    ctrl_t w;
    w.unit = u; w.op = o; w.single = 1'b0;
    return w;
  endfunction

  function automatic ctrl_t major_word(input logic [MAJ_W-1:0] m);
    case (m)
      6'd14:   return mk(U_ALU, OP_ADD);
      6'd24:   return mk(U_ALU, OP_OR);
      6'd32:   return mk(U_LSU, OP_LOAD);
      6'd36:   return mk(U_LSU, OP_STORE);
      6'd18:   return mk(U_BRU, OP_BR);
      6'd16:   return mk(U_BRU, OP_BC);
      default: return CW_ILLEGAL;
    endcase
  endfunction

  function automatic logic op4_ok(input logic [10:0] idx);
    logic [5:0] sub;
    logic [4:0] ext;
    sub = idx[10:5];
    ext = idx[4:0];
    return (sub == 6'd48) || (sub == 6'd49) || ((sub == 6'd51) && (ext == 5'd0));
  endfunction

  function automatic ctrl_t op4_word(input logic [5:0] sub);
    case (sub)
      6'd48, 6'd49, 6'd51: return mk(U_ALU, OP_MULADD);
      default:             return CW_ILLEGAL;
    endcase
  endfunction

  function automatic logic op19_ok(input logic [9:0] idx);
    logic [4:0] hi;
    logic [4:0] lo;
    hi = idx[9:5];
    lo = idx[4:0];
    return (hi == 5'b00010) || ((hi == 5'b10000) && (lo == 5'b10000)) ||
           ((hi == 5'd0) && (lo == 5'd0));
  endfunction

  function automatic ctrl_t op19_word(input logic [2:0] sel);
    case (sel)
      3'd0:    return mk(U_ALU, OP_MCRF);
      3'd1:    return mk(U_ALU, OP_ADDPC);
      3'd4:    return mk(U_BRU, OP_BCREG);
      default: return mk(U_ALU, OP_CRL);
    endcase
  endfunction

  function automatic ctrl_t op31_word(input logic [XO_W-1:0] xo);
    if (xo == XO31_ADD)                          return mk(U_ALU, OP_ADD);
    if (xo == XO31_LOAD)                         return mk(U_LSU, OP_LOAD);
    if ((xo == XO31_MFSPR) || (xo == XO31_MTSPR)) return mk(U_ALU, OP_SPR);
    return CW_ILLEGAL;
  endfunction

  always_comb begin
    valid_o = valid_i;
    ovr_o   = OVR_NONE;
    base_o  = major_word(major);
    case (major)
      6'd4: begin
        ovr_o.full = !op4_ok({insn_i[5:0], insn_i[10:6]});
        base_o     = op4_word(insn_i[5:0]);
      end
      6'd19: begin
        ovr_o.full = !op19_ok({insn_i[5:1], insn_i[10:6]});
        base_o     = op19_word({insn_i[5], insn_i[3], insn_i[2]});
      end
      6'd31: begin
        base_o = op31_word(xo31);
        if (((xo31 == XO31_MFSPR) || (xo31 == XO31_MTSPR)) && !spr_is_fast(sprn)) begin
          ovr_o.single = 1'b1;
          if (spr_is_mmu(sprn)) begin
            ovr_o.unit_only = 1'b1;
            ovr_o.word.unit = U_LSU;
          end
        end
      end
      NOP_MAJ: begin
        if (insn_i == NOP_PATTERN) begin
          ovr_o.full = 1'b1;
          ovr_o.word = CW_NOP;
        end
      end
      default: ;
    endcase
    if (fetch_fail_i) begin
      valid_o    = !held_ffail_i;
      ovr_o.full = 1'b1;
      ovr_o.word = CW_FFAIL;
    end
  end
endmodule

// File: rtl/dec_skid.sv
module dec_skid #(
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-1:0] RST_DATA = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              stall_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o
);
  logic              r_v, s_v;
  logic [DATA_W-1:0] r_d, s_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_v <= 1'b0;
      s_v <= 1'b0;
      r_d <= RST_DATA;
      s_d <= RST_DATA;
    end else if (flush_i) begin
      r_v <= 1'b0;
      s_v <= 1'b0;
    end else if (s_v) begin
      if (!stall_i) begin
        r_v <= 1'b1;
        r_d <= s_d;
        s_v <= 1'b0;
      end
    end else begin
      s_d <= data_i;
      s_v <= valid_i & r_v & stall_i;
      if (!r_v || !stall_i) begin
        r_v <= valid_i;
        r_d <= data_i;
      end
    end
  end

  assign valid_o = r_v;
  assign data_o  = r_d;
  assign busy_o  = s_v;
endmodule

// File: rtl/dec_patch.sv
module dec_patch
  import dec_pkg::*;
(
  input  ctrl_t base_i,
  input  ovr_t  ovr_i,
  output ctrl_t word_o
);
  always_comb begin
    word_o = base_i;
    if (ovr_i.full)           word_o = ovr_i.word;
    else if (ovr_i.unit_only) word_o.unit = ovr_i.word.unit;
    if (ovr_i.single)         word_o.single = 1'b1;
  end
endmodule

// File: rtl/dec_stage.sv
module dec_stage
  import dec_pkg::*;
#(
  parameter logic [31:0] NOP_PATTERN = 32'h6000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        stall_i,
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  input  logic        fetch_fail_i,
  output logic        valid_o,
  output logic        busy_o,
  output logic [31:0] insn_o,
  output logic [1:0]  unit_o,
  output logic [3:0]  op_o,
  output logic        single_o
);
  localparam int SLOT_W = $bits(slot_t);

  logic  lk_valid;
  ctrl_t lk_base;
  ovr_t  lk_ovr;
  slot_t in_slot, held;
  logic  held_ffail;
  ctrl_t word;

  assign held_ffail = held.ovr.full && (held.ovr.word.op == OP_FFAIL);

  dec_lookup #(.NOP_PATTERN(NOP_PATTERN)) u_lookup (
    .insn_i       (insn_i),
    .valid_i      (valid_i),
    .fetch_fail_i (fetch_fail_i),
    .held_ffail_i (held_ffail),
    .valid_o      (lk_valid),
    .base_o       (lk_base),
    .ovr_o        (lk_ovr)
  );

  assign in_slot = '{insn: insn_i, base: lk_base, ovr: lk_ovr};

  dec_skid #(.DATA_W(SLOT_W), .RST_DATA(SLOT_RST)) u_skid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .stall_i (stall_i),
    .valid_i (lk_valid),
    .data_i  (in_slot),
    .valid_o (valid_o),
    .data_o  (held),
    .busy_o  (busy_o)
  );

  dec_patch u_patch (
    .base_i (held.base),
    .ovr_i  (held.ovr),
    .word_o (word)
  );

  assign insn_o   = held.insn;
  assign unit_o   = word.unit;
  assign op_o     = word.op;
  assign single_o = word.single;
endmodule

// File: rtl/dec_stage_chk.sv
module dec_stage_chk
  import dec_pkg::*;
#(
  parameter logic [31:0] NOP_PATTERN = 32'h6000_0000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        flush_i,
  input logic        stall_i,
  input logic        valid_o,
  input logic        busy_o,
  input logic [31:0] insn_o,
  input logic [1:0]  unit_o,
  input logic [3:0]  op_o,
  input logic        single_o
);
  logic [SPR_W-1:0] out_sprn;
  assign out_sprn = {insn_o[15:11], insn_o[20:16]};

  p_busy_has_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> valid_o);

  p_hold_on_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stall_i && !flush_i) |=>
      (valid_o && $stable(insn_o) && $stable(unit_o) && $stable(op_o) && $stable(single_o)));

  p_flush_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!valid_o && !busy_o));

  p_illegal_no_unit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_o == OP_ILL) |-> (unit_o == U_NONE));

  p_nop_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && insn_o == NOP_PATTERN && op_o != OP_FFAIL) |-> (op_o == OP_NOP && unit_o == U_ALU));

  p_ffail_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_o == OP_FFAIL) |-> (single_o && unit_o == U_ALU));

  p_one_ffail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_o == OP_FFAIL && !stall_i && !flush_i) |=> !(valid_o && op_o == OP_FFAIL));

  p_spr_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_o == OP_SPR) |-> (single_o == !spr_is_fast(out_sprn)));

  p_spr_unit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_o == OP_SPR) |-> (unit_o == (spr_is_mmu(out_sprn) ? U_LSU : U_ALU)));
endmodule

bind dec_stage dec_stage_chk #(.NOP_PATTERN(NOP_PATTERN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .flush_i  (flush_i),
  .stall_i  (stall_i),
  .valid_o  (valid_o),
  .busy_o   (busy_o),
  .insn_o   (insn_o),
  .unit_o   (unit_o),
  .op_o     (op_o),
  .single_o (single_o)
);

// File: tb/tb_dec_stage.sv
module tb_dec_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 31;

  // {req[3:0], insn[31:0], unit[1:0], op[3:0], single}
  localparam logic [42:0] VEC [NV] = '{
    {4'd1, 32'h3800_0000, 2'd1, 4'd2,  1'b0},  // R1 add-imm
    {4'd1, 32'h8000_0000, 2'd2, 4'd4,  1'b0},  // R1 load
    {4'd1, 32'h9000_0000, 2'd2, 4'd5,  1'b0},  // R1 store
    {4'd1, 32'h4800_0000, 2'd3, 4'd6,  1'b0},  // R1 branch
    {4'd1, 32'h4000_0000, 2'd3, 4'd7,  1'b0},  // R1 cond branch
    {4'd1, 32'h0400_0000, 2'd0, 4'd0,  1'b0},  // R1 unknown major
    {4'd1, 32'h7C00_0214, 2'd1, 4'd2,  1'b0},  // R1 minor add
    {4'd1, 32'h7C00_002E, 2'd2, 4'd4,  1'b0},  // R1 minor load
    {4'd1, 32'h7C00_03FE, 2'd0, 4'd0,  1'b0},  // R1 unknown minor
    {4'd4, 32'h6000_0000, 2'd1, 4'd1,  1'b0},  // R4 nop
    {4'd4, 32'h6001_0000, 2'd1, 4'd3,  1'b0},  // R4 or
    {4'd4, 32'h6000_0001, 2'd1, 4'd3,  1'b0},  // R4 or
    {4'd6, 32'h7C08_02A6, 2'd1, 4'd12, 1'b0},  // R6 fast 8
    {4'd6, 32'h7C09_03A6, 2'd1, 4'd12, 1'b0},  // R6 fast 9
    {4'd6, 32'h7C1A_02A6, 2'd1, 4'd12, 1'b1},  // R6 slow 26
    {4'd7, 32'h7C13_03A6, 2'd2, 4'd12, 1'b1},  // R7 mmu 19 unit only
    {4'd6, 32'h7C10_B2A6, 2'd2, 4'd12, 1'b1},  // R6 mmu 720
    {4'd6, 32'h7C12_02A6, 2'd2, 4'd12, 1'b1},  // R6 mmu 18
    {4'd6, 32'h7C10_0AA6, 2'd2, 4'd12, 1'b1},  // R6 mmu 48
    {4'd2, 32'h4C00_0000, 2'd1, 4'd14, 1'b0},  // R2 sel 0
    {4'd2, 32'h4C00_07C4, 2'd1, 4'd10, 1'b0},  // R2 sel 1
    {4'd2, 32'h4C00_0420, 2'd3, 4'd8,  1'b0},  // R2 sel 4
    {4'd2, 32'h4C00_0020, 2'd0, 4'd0,  1'b0},  // R2 invalid lower
    {4'd2, 32'h4C00_0040, 2'd0, 4'd0,  1'b0},  // R2 invalid
    {4'd3, 32'h1000_0030, 2'd1, 4'd11, 1'b0},  // R3 48
    {4'd3, 32'h1000_0170, 2'd1, 4'd11, 1'b0},  // R3 48 ext 5
    {4'd3, 32'h1000_0031, 2'd1, 4'd11, 1'b0},  // R3 49
    {4'd3, 32'h1000_0033, 2'd1, 4'd11, 1'b0},  // R3 51 ext 0
    {4'd3, 32'h1000_0073, 2'd0, 4'd0,  1'b0},  // R3 51 ext 1 invalid
    {4'd3, 32'h1000_0002, 2'd0, 4'd0,  1'b0},  // R3 invalid sub
    {4'd1, 32'h7C00_0214, 2'd1, 4'd2,  1'b0}   // R1 after illegal
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0, stall_i = 1'b0, valid_i = 1'b0, fetch_fail_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic        valid_o, busy_o, single_o;
  logic [31:0] insn_o;
  logic [1:0]  unit_o;
  logic [3:0]  op_o;
  int          n_tests = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_stage dut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .stall_i(stall_i),
    .valid_i(valid_i), .insn_i(insn_i), .fetch_fail_i(fetch_fail_i),
    .valid_o(valid_o), .busy_o(busy_o), .insn_o(insn_o),
    .unit_o(unit_o), .op_o(op_o), .single_o(single_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] obs();
    return {valid_o, unit_o, op_o, single_o};
  endfunction

  function automatic logic [7:0] ew(input logic [1:0] u, input logic [3:0] o, input logic s);
    return {1'b1, u, o, s};
  endfunction

  localparam logic [31:0] W_MMU  = 32'h7C13_03A6;
  localparam logic [31:0] W_NOP  = 32'h6000_0000;
  localparam logic [31:0] W_ADD  = 32'h3800_0000;
  localparam logic [31:0] W_FAST = 32'h7C08_02A6;

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid/busy", {valid_o, busy_o}, 2'b00);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      valid_i = 1'b1;
      insn_i  = VEC[i][38:7];
      @(negedge clk);
      chk($sformatf("R%0d vector %0d insn %h", VEC[i][42:39], i, VEC[i][38:7]),
          obs(), {1'b1, VEC[i][6:0]});
    end

    // R8 / R11: skid pairing
    insn_i = W_MMU; stall_i = 1'b0;
    @(negedge clk);
    chk("R11 first entry word", obs(), ew(2'd2, 4'd12, 1'b1));
    chk("R8 no busy", busy_o, 1'b0);
    insn_i = W_NOP; stall_i = 1'b1;
    @(negedge clk);
    chk("R8 hold under stall", {insn_o, obs()}, {W_MMU, ew(2'd2, 4'd12, 1'b1)});
    chk("R8 busy after skid capture", busy_o, 1'b1);
    insn_i = W_ADD;
    @(negedge clk);
    chk("R11 still first entry", {insn_o, obs()}, {W_MMU, ew(2'd2, 4'd12, 1'b1)});
    chk("R8 busy held", busy_o, 1'b1);
    stall_i = 1'b0;
    @(negedge clk);
    chk("R11 second entry with own override", {insn_o, obs()}, {W_NOP, ew(2'd1, 4'd1, 1'b0)});
    chk("R8 busy cleared", busy_o, 1'b0);
    insn_i = W_FAST;
    @(negedge clk);
    chk("R8 word offered while busy dropped", {insn_o, obs()}, {W_FAST, ew(2'd1, 4'd12, 1'b0)});
    valid_i = 1'b0;
    @(negedge clk);
    chk("R8 bubble", valid_o, 1'b0);

    // R9 flush
    valid_i = 1'b1; insn_i = W_MMU;
    @(negedge clk);
    insn_i = W_NOP; stall_i = 1'b1;
    @(negedge clk);
    chk("R9 pre-flush busy", busy_o, 1'b1);
    flush_i = 1'b1; insn_i = W_ADD;
    @(negedge clk);
    chk("R9 flush clears both", {valid_o, busy_o}, 2'b00);
    flush_i = 1'b0; stall_i = 1'b0; insn_i = W_ADD;
    @(negedge clk);
    chk("R9 resume after flush", {insn_o, obs()}, {W_ADD, ew(2'd1, 4'd2, 1'b0)});

    // R5 / R7 fetch failure
    valid_i = 1'b0; fetch_fail_i = 1'b1; insn_i = W_MMU;
    @(negedge clk);
    chk("R5 R7 fetch fail word beats redirect", obs(), ew(2'd1, 4'd13, 1'b1));
    @(negedge clk);
    chk("R5 repeated failure dropped", valid_o, 1'b0);
    @(negedge clk);
    chk("R5 still dropped", valid_o, 1'b0);
    fetch_fail_i = 1'b0; valid_i = 1'b1; insn_i = W_ADD;
    @(negedge clk);
    chk("R5 normal after failure", obs(), ew(2'd1, 4'd2, 1'b0));
    fetch_fail_i = 1'b1;
    @(negedge clk);
    chk("R5 new failure passes", obs(), ew(2'd1, 4'd13, 1'b1));
    fetch_fail_i = 1'b0;

    // R10 asynchronous reset with both entries full
    insn_i = W_ADD;
    @(negedge clk);
    insn_i = W_NOP; stall_i = 1'b1;
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R10 async reset clears", {valid_o, busy_o}, 2'b00);
    valid_i = 1'b0; stall_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", {valid_o, busy_o}, 2'b00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule